// File: doc/BRIEF.md
# Hex-Dump Serial Reporter

This block turns the contents of a small frame buffer into a line of printable text and shifts it out on a single asynchronous serial pin. A one-cycle start pulse begins a report. A select input sampled with that pulse chooses between two report kinds. A success report reads each buffer entry through a byte-read port and prints it as two uppercase hexadecimal digits followed by a blank. An error report prints only a question mark.

Every report opens with a carriage return and a line feed. Each character is framed as one start bit, eight data bits sent least significant bit first, and two stop bits. The line levels are inverted, so the pin can feed a PC serial input directly, with no inverting buffer in between. The bit period is the system clock divided down to 9600 baud. A busy flag covers the whole report.

Top module: `hexdump_uart_tx`

## Requirements
- R1: Each character takes exactly 11 bit times. A bit time is CLK_HZ/BAUD clock cycles. Characters of one report follow each other with no gap.
- R2: Line polarity is inverted. The start bit drives ser_out high, both stop bits drive it low, a data 1 drives it low and a data 0 drives it high.
- R3: Data bits go out least significant bit first. The data bits occupy bit slots 1 to 8 of the character, and slot 0 is the start bit.
- R4: Every report begins with 0x0D and then 0x0A.
- R5: A success report (report_err low at start) then sends, for buffer addresses 0 to NUM_BYTES-1 in rising order, the high-nibble digit, the low-nibble digit and 0x20. That is 2+3*NUM_BYTES characters in all.
- R6: A nibble value n of 0 to 9 is sent as 0x30+n. A value of 10 to 15 is sent as 0x37+n, which gives uppercase 'A' to 'F'.
- R7: An error report (report_err high at start) sends 0x3F after the opening pair and nothing more, so it is 3 characters long.
- R8: When idle, ser_out is low and busy is low, and this is also the state after reset. busy rises at the clock edge that samples start. busy stays high until the edge that ends the last stop bit, and falls there.
- R9: A start pulse or a report_err change while busy has no effect on the report in progress.
- R10: While busy, rd_addr stays below NUM_BYTES. The buffer byte is read combinationally at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a report, ignored while busy |
| report_err | input | 1 | Sampled with start: 1 gives an error report, 0 gives a hex dump |
| rd_addr | output | $clog2(NUM_BYTES) | Address of the buffer byte being read |
| rd_data | input | 8 | Buffer byte at rd_addr |
| busy | output | 1 | High while a report is being sent |
| ser_out | output | 1 | Inverted-polarity serial output |

## Verification
The success path is driven with buffer contents that together sweep all 256 byte values, so every nibble value lands in both the high and the low digit position. This separates the decimal and the letter branch of the digit mapping, and it also exposes nibble-order or bit-order swaps. An error report shows whether the select input picks the short form and stops after one character. A report with a start pulse and a flipped select injected mid-way shows whether a busy transmitter can be restarted or have its report kind switched. Each character is decoded from mid-bit samples, so framing, polarity and gapless timing are judged at the pin alone.

// File: rtl/hexdump_uart_tx.sv
module hexdump_uart_tx #(
  parameter int CLK_HZ    = 12_000_000,
  parameter int BAUD      = 9600,
  parameter int NUM_BYTES = 10,
  localparam int AW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          report_err,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          ser_out
);

  localparam int DIV = CLK_HZ / BAUD;
  localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_CR, ST_LF, ST_QM, ST_HI, ST_LO, ST_SP} stage_t;

  stage_t        stage, nxt_stage;
  logic [7:0]    shreg, nxt_char;
  logic [3:0]    bitn;
  logic [DW-1:0] div;
  logic [AW-1:0] idx;
  logic          err_q;
  logic          last_byte, bit_end;

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
  endfunction

  assign last_byte = (idx == AW'(NUM_BYTES - 1));
  assign rd_addr   = (stage == ST_SP && !last_byte) ? idx + 1'b1 : idx;
  assign busy      = (stage != ST_IDLE);
  assign bit_end   = busy && (div == DW'(DIV - 1));
  assign ser_out   = busy && ((bitn == 4'd0) || (bitn <= 4'd8 && !shreg[0]));

  always_comb begin
    nxt_stage = ST_IDLE;
    nxt_char  = 8'h00;
    case (stage)
      ST_CR: begin nxt_stage = ST_LF; nxt_char = 8'h0A; end
      ST_LF: begin
        if (err_q) begin nxt_stage = ST_QM; nxt_char = 8'h3F; end
        else begin nxt_stage = ST_HI; nxt_char = hexc(rd_data[7:4]); end
      end
      ST_HI: begin nxt_stage = ST_LO; nxt_char = hexc(rd_data[3:0]); end
      ST_LO: begin nxt_stage = ST_SP; nxt_char = 8'h20; end
      ST_SP: begin
        if (!last_byte) begin nxt_stage = ST_HI; nxt_char = hexc(rd_data[7:4]); end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= ST_IDLE;
      shreg <= 8'h00;
      bitn  <= 4'd0;
      div   <= '0;
      idx   <= '0;
      err_q <= 1'b0;
    end else if (stage == ST_IDLE) begin
      if (start) begin
        stage <= ST_CR;
        shreg <= 8'h0D;
        bitn  <= 4'd0;
        div   <= '0;
        idx   <= '0;
        err_q <= report_err;
      end
    end else if (bit_end) begin
      div <= '0;
      if (bitn == 4'd10) begin
        stage <= nxt_stage;
        shreg <= nxt_char;
        bitn  <= 4'd0;
        if (stage == ST_SP) idx <= idx + 1'b1;
      end else begin
        bitn <= bitn + 4'd1;
        if (bitn != 4'd0 && bitn < 4'd9) shreg <= shreg >> 1;
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && div != '0) |-> $stable(ser_out));

  assert_end_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bitn) == 4'd10 && $past(div) == DW'(DIV - 1) && !ser_out));

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(bit_end && bitn == 4'd10)) |=> ($stable(stage) && $stable(err_q)));

  assert_addr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_addr < AW'(NUM_BYTES)));

  assert_err_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_HI || stage == ST_LO || stage == ST_SP) |-> !err_q);

endmodule

// File: tb/tb_hexdump_uart_tx.sv
module tb_hexdump_uart_tx;
  localparam int D  = 4;
  localparam int N  = 10;
  localparam int CW = 11 * D;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, err_sel = 1'b0;
  logic busy, ser_out;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] mem [N];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  assign rd_data = (rd_addr < 4'(N)) ? mem[rd_addr] : 8'h00;

  hexdump_uart_tx #(.CLK_HZ(9600 * D), .BAUD(9600), .NUM_BYTES(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .report_err(err_sel),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .ser_out(ser_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexd(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [7:0] exp_char(input bit e, input int c);
    int k;
    if (c == 0) return 8'h0D;
    if (c == 1) return 8'h0A;
    if (e) return 8'h3F;
    k = c - 2;
    case (k % 3)
      0: return hexd(int'(mem[k / 3][7:4]));
      1: return hexd(int'(mem[k / 3][3:0]));
      default: return 8'h20;
    endcase
  endfunction

  task automatic run_report(input bit e, input bit inject);
    int total;
    logic [10:0] bits;
    string tag;
    total = e ? 3 : 2 + 3 * N;
    bits = '0;
    @(negedge clk);
    err_sel = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= total * CW; j++) begin
      if (j < total * CW) begin
        int c, b;
        c = j / CW;
        b = (j / D) % 11;
        if (!busy) chk(1'b0, "R8 busy during report", 0, 1);
        if (rd_addr >= 4'(N)) chk(1'b0, "R10 rd_addr range", int'(rd_addr), N - 1);
        if (j % D == D / 2) begin
          bits[b] = ser_out;
          if (b == 10) begin
            tag = e ? "R7" : (c < 2 ? "R4" : "R5/R6");
            if (inject) tag = {tag, " R9"};
            chk(bits[0] == 1'b1, "R1/R2 start bit high", int'(bits[0]), 1);
            chk(bits[10:9] == 2'b00, "R1/R2 stop bits low", int'(bits[10:9]), 0);
            chk((~bits[8:1]) == exp_char(e, c), {tag, " R3 character"},
                int'(~bits[8:1]), int'(exp_char(e, c)));
          end
        end
      end else begin
        chk(!busy && !ser_out, "R8 busy falls after last stop", int'({busy, ser_out}), 0);
      end
      if (inject && j == 150) begin
        start = 1'b1;
        err_sel = ~e;
      end else if (inject && j == 151) begin
        start = 1'b0;
        err_sel = e;
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !ser_out, "R8 idle line low", int'({busy, ser_out}), 0);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ser_out, "R8 reset state", int'({busy, ser_out}), 0);
    for (int r = 0; r < 26; r++) begin
      for (int i = 0; i < N; i++) mem[i] = 8'((r * N + i) % 256);
      run_report(1'b0, 1'b0);
    end
    run_report(1'b1, 1'b0);
    for (int i = 0; i < N; i++) mem[i] = 8'(8'hA5 ^ (i * 37));
    run_report(1'b0, 1'b1);
    run_report(1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule